// File: doc/BRIEF.md
# GPIO Pad Ownership and Configuration Cell

This cell sits beside one I/O pad and keeps a private copy of that pad's 13-bit configuration word. A central configuration controller presents a new word and pulses a load strobe. The cell captures the word on that clock edge and holds it until the next strobe. The stored word drives the pad's static controls directly: drive mode, trip point, slew, analog routing, input disable and hold.

The cell also decides who owns the pad's three dynamic signals: the value going out, the output enable and the value coming in. One configuration bit gives the pad either to user logic or to the management processor. The cell comes in two variants, chosen by a parameter.

- **Full-triple variant.** The management side owns a complete out/oe/in set.
- **Single-wire variant.** The management side has one logical wire. Its direction follows the output-disable bit. In the two pull modes the wire always works as an input, and the pad's output value is forced locally so that the pull resistor is biased correctly.

Top module: `pad_ctl_cell`

## Requirements
- R1: After synchronous reset, a single-wire cell holds word 0x0403: mode 001 on `pad_mode_o`, management ownership, output disabled (`pad_oe_o`=0), and every other static output 0.
- R2: After synchronous reset, a full-triple cell holds word 0x1801: mode 110 with management ownership, so `pad_oe_o` follows `mgmt_oe_i` and `pad_out_o` follows `mgmt_out_i`.
- R3: The stored word is replaced by `cfg_word_i` only on a rising edge where `cfg_load_i` is 1, and the change is visible from that edge on. Without the strobe, a changing `cfg_word_i` has no effect.
- R4: When bit 0 (management enable) is 0, `pad_out_o`=`user_out_i`, `pad_oe_o`=`user_oe_i`, `user_in_o` returns the pad input, and `mgmt_in_o` reads 0.
- R5: On a full-triple cell with bit 0 = 1, `pad_out_o`=`mgmt_out_i`, `pad_oe_o`=`mgmt_oe_i` whatever bit 1 holds, `mgmt_in_o` returns the pad input, and `user_in_o` reads 0.
- R6: On a single-wire cell with bit 0 = 1, bit 1 = 0 and a mode other than 010 or 011, the wire drives the pad: `pad_out_o`=`mgmt_out_i`, `pad_oe_o`=1 whatever `mgmt_oe_i` holds, and `mgmt_in_o`=0.
- R7: On a single-wire cell with bit 0 = 1, bit 1 = 1 and a mode other than 010 or 011, the wire returns the pad input on `mgmt_in_o`, with `pad_oe_o`=0 and `pad_out_o`=0.
- R8: On a single-wire cell under management in mode 010 (pull-up) or 011 (pull-down), `pad_out_o` is forced to the inverse of mode bit 0 (1 for 010, 0 for 011) and ignores `mgmt_out_i`. `mgmt_in_o` returns the pad input, and `pad_oe_o` is the inverse of bit 1.
- R9: While bit 3 (input disable) is 1, both `user_in_o` and `mgmt_in_o` read 0 whatever `pad_in_i` holds.
- R10: The static outputs map to the stored word as follows: bits 12:10 mode, 9 trip, 8 slew, 7 analog polarity, 6 analog select, 5 analog enable, 4 IB mode, 3 input disable, 2 hold. They do not depend on who owns the pad.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_word_i | input | 13 | Configuration word from the central controller |
| cfg_load_i | input | 1 | Transfer strobe; captures `cfg_word_i` |
| user_out_i | input | 1 | User value to drive on the pad |
| user_oe_i | input | 1 | User output enable |
| user_in_o | output | 1 | Pad input returned to the user |
| mgmt_out_i | input | 1 | Management value to drive (the single wire's outgoing direction) |
| mgmt_oe_i | input | 1 | Management output enable (full-triple variant only) |
| mgmt_in_o | output | 1 | Pad input returned to management (the single wire's return direction) |
| pad_in_i | input | 1 | Value sensed at the pad |
| pad_out_o | output | 1 | Value driven to the pad |
| pad_oe_o | output | 1 | Pad output enable |
| pad_mode_o | output | 3 | Pad drive mode |
| pad_trip_o | output | 1 | Input trip-point select |
| pad_slew_o | output | 1 | Slow slew select |
| pad_ana_pol_o | output | 1 | Analog bus polarity |
| pad_ana_sel_o | output | 1 | Analog bus select |
| pad_ana_en_o | output | 1 | Analog bus enable |
| pad_ib_o | output | 1 | IB mode select |
| pad_inp_dis_o | output | 1 | Input disable |
| pad_hold_o | output | 1 | Holdover value |

## Verification
A transfer strobe and the routing of the dynamic signals can land in the same cycle. A strobe that hands the pad from management to the user can arrive while both sides present different output values. The bench raises the strobe at a falling edge with a new word that flips the ownership bit, and drives opposite values on `mgmt_out_i` and `user_out_i`. It first samples `pad_out_o` before the rising edge and expects the old owner's value. It samples again after the edge and expects the new owner's value. This shows that the routing follows the stored word, not the word waiting at the input.

// File: rtl/pad_ctl_pkg.sv
package pad_ctl_pkg;

  localparam int unsigned MODE_W = 3;
  localparam int unsigned CFG_W  = 13;

  typedef struct packed {
    logic [MODE_W-1:0] mode;     // 12:10
    logic              trip;     // 9
    logic              slew;     // 8
    logic              ana_pol;  // 7
    logic              ana_sel;  // 6
    logic              ana_en;   // 5
    logic              ib;       // 4
    logic              inp_dis;  // 3
    logic              hold;     // 2
    logic              out_dis;  // 1
    logic              mgmt_en;  // 0
  } pad_cfg_t;

  // Reset words for the two cell variants
  localparam logic [CFG_W-1:0] RST_SINGLE = 13'h0403;
  localparam logic [CFG_W-1:0] RST_FULL   = 13'h1801;

  localparam logic [MODE_W-1:0] MODE_PULL_UP   = 3'b010;
  localparam logic [MODE_W-1:0] MODE_PULL_DOWN = 3'b011;

endpackage

// File: rtl/pad_cfg_store.sv
module pad_cfg_store
  import pad_ctl_pkg::*;
#(
  parameter logic [CFG_W-1:0] RST_VAL = RST_SINGLE
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CFG_W-1:0] word_i,
  input  logic             load_i,
  output pad_cfg_t         cfg_o
);

  pad_cfg_t cfg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= pad_cfg_t'(RST_VAL);
    end else if (load_i) begin
      cfg_q <= pad_cfg_t'(word_i);
    end
  end

  assign cfg_o = cfg_q;

  // R3
  hold_without_load_chk: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> $stable(cfg_q));

  // R3
  capture_on_load_chk: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (cfg_q == pad_cfg_t'($past(word_i))));

endmodule

// File: rtl/pad_route_mux.sv
module pad_route_mux
  import pad_ctl_pkg::*;
#(
  parameter bit FULL_TRIPLE = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              inp_dis_i,
  input  logic              out_dis_i,
  input  logic              mgmt_en_i,
  input  logic              user_out_i,
  input  logic              user_oe_i,
  output logic              user_in_o,
  input  logic              mgmt_out_i,
  input  logic              mgmt_oe_i,
  output logic              mgmt_in_o,
  input  logic              pad_in_i,
  output logic              pad_out_o,
  output logic              pad_oe_o
);

  logic in_gated;
  logic pull_mode;
  logic m_out, m_oe, m_in;

  assign in_gated  = pad_in_i & ~inp_dis_i;
  assign pull_mode = (mode_i == MODE_PULL_UP) || (mode_i == MODE_PULL_DOWN);

  generate
    if (FULL_TRIPLE) begin : g_full
      assign m_out = mgmt_out_i;
      assign m_oe  = mgmt_oe_i;
      assign m_in  = in_gated;

      // R5
      full_oe_ignores_cfg_chk: assert property (@(posedge clk) disable iff (rst)
        (mgmt_en_i && out_dis_i && mgmt_oe_i) |-> pad_oe_o);
    end else begin : g_single
      logic wire_is_input;
      assign wire_is_input = pull_mode | out_dis_i;
      assign m_oe  = ~out_dis_i;
      assign m_out = pull_mode ? ~mode_i[0] : (out_dis_i ? 1'b0 : mgmt_out_i);
      assign m_in  = wire_is_input ? in_gated : 1'b0;

      // R6
      single_oe_ignores_port_chk: assert property (@(posedge clk) disable iff (rst)
        (mgmt_en_i && !out_dis_i && !mgmt_oe_i) |-> pad_oe_o);

      // R8
      pull_forces_out_chk: assert property (@(posedge clk) disable iff (rst)
        (mgmt_en_i && pull_mode) |-> (pad_out_o == !mode_i[0]));
    end
  endgenerate

  always_comb begin
    if (mgmt_en_i) begin
      pad_out_o = m_out;
      pad_oe_o  = m_oe;
      mgmt_in_o = m_in;
      user_in_o = 1'b0;
    end else begin
      pad_out_o = user_out_i;
      pad_oe_o  = user_oe_i;
      mgmt_in_o = 1'b0;
      user_in_o = in_gated;
    end
  end

  // R4
  user_owns_pad_chk: assert property (@(posedge clk) disable iff (rst)
    !mgmt_en_i |-> (pad_out_o == user_out_i) && (pad_oe_o == user_oe_i) && !mgmt_in_o);

  // R9
  input_blocked_chk: assert property (@(posedge clk) disable iff (rst)
    inp_dis_i |-> (!user_in_o && !mgmt_in_o));

endmodule

// File: rtl/pad_ctl_cell.sv
module pad_ctl_cell
  import pad_ctl_pkg::*;
#(
  parameter bit FULL_TRIPLE = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CFG_W-1:0]  cfg_word_i,
  input  logic              cfg_load_i,
  input  logic              user_out_i,
  input  logic              user_oe_i,
  output logic              user_in_o,
  input  logic              mgmt_out_i,
  input  logic              mgmt_oe_i,
  output logic              mgmt_in_o,
  input  logic              pad_in_i,
  output logic              pad_out_o,
  output logic              pad_oe_o,
  output logic [MODE_W-1:0] pad_mode_o,
  output logic              pad_trip_o,
  output logic              pad_slew_o,
  output logic              pad_ana_pol_o,
  output logic              pad_ana_sel_o,
  output logic              pad_ana_en_o,
  output logic              pad_ib_o,
  output logic              pad_inp_dis_o,
  output logic              pad_hold_o
);

  localparam logic [CFG_W-1:0] RST_WORD = FULL_TRIPLE ? RST_FULL : RST_SINGLE;

  pad_cfg_t cfg;

  pad_cfg_store #(
    .RST_VAL (RST_WORD)
  ) u_store (
    .clk    (clk),
    .rst    (rst),
    .word_i (cfg_word_i),
    .load_i (cfg_load_i),
    .cfg_o  (cfg)
  );

  pad_route_mux #(
    .FULL_TRIPLE (FULL_TRIPLE)
  ) u_mux (
    .clk        (clk),
    .rst        (rst),
    .mode_i     (cfg.mode),
    .inp_dis_i  (cfg.inp_dis),
    .out_dis_i  (cfg.out_dis),
    .mgmt_en_i  (cfg.mgmt_en),
    .user_out_i (user_out_i),
    .user_oe_i  (user_oe_i),
    .user_in_o  (user_in_o),
    .mgmt_out_i (mgmt_out_i),
    .mgmt_oe_i  (mgmt_oe_i),
    .mgmt_in_o  (mgmt_in_o),
    .pad_in_i   (pad_in_i),
    .pad_out_o  (pad_out_o),
    .pad_oe_o   (pad_oe_o)
  );

  // Static pad controls come straight from the held word
  assign pad_mode_o    = cfg.mode;
  assign pad_trip_o    = cfg.trip;
  assign pad_slew_o    = cfg.slew;
  assign pad_ana_pol_o = cfg.ana_pol;
  assign pad_ana_sel_o = cfg.ana_sel;
  assign pad_ana_en_o  = cfg.ana_en;
  assign pad_ib_o      = cfg.ib;
  assign pad_inp_dis_o = cfg.inp_dis;
  assign pad_hold_o    = cfg.hold;

  // R3
  static_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_load_i |=> $stable(pad_mode_o) && $stable(pad_hold_o) && $stable(pad_trip_o));

endmodule

// File: tb/test_pad_ctl_cell.sv
`timescale 1ns/1ps
module test_pad_ctl_cell;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [12:0] cfg_word = '0;
  logic        cfg_load = 1'b0;
  logic        user_out = 1'b0, user_oe = 1'b0;
  logic        mgmt_out = 1'b0, mgmt_oe = 1'b0;
  logic        pad_in = 1'b0;

  logic        s_user_in, s_mgmt_in, s_pad_out, s_pad_oe;
  logic [2:0]  s_mode;
  logic        s_trip, s_slew, s_pol, s_sel, s_aen, s_ib, s_idis, s_hold;

  logic        f_user_in, f_mgmt_in, f_pad_out, f_pad_oe;
  logic [2:0]  f_mode;
  logic        f_trip, f_slew, f_pol, f_sel, f_aen, f_ib, f_idis, f_hold;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  pad_ctl_cell #(.FULL_TRIPLE(1'b0)) i_pad_ctl_cell (
    .clk(clk), .rst(rst), .cfg_word_i(cfg_word), .cfg_load_i(cfg_load),
    .user_out_i(user_out), .user_oe_i(user_oe), .user_in_o(s_user_in),
    .mgmt_out_i(mgmt_out), .mgmt_oe_i(mgmt_oe), .mgmt_in_o(s_mgmt_in),
    .pad_in_i(pad_in), .pad_out_o(s_pad_out), .pad_oe_o(s_pad_oe),
    .pad_mode_o(s_mode), .pad_trip_o(s_trip), .pad_slew_o(s_slew),
    .pad_ana_pol_o(s_pol), .pad_ana_sel_o(s_sel), .pad_ana_en_o(s_aen),
    .pad_ib_o(s_ib), .pad_inp_dis_o(s_idis), .pad_hold_o(s_hold));

  pad_ctl_cell #(.FULL_TRIPLE(1'b1)) i_pad_ctl_cell_full (
    .clk(clk), .rst(rst), .cfg_word_i(cfg_word), .cfg_load_i(cfg_load),
    .user_out_i(user_out), .user_oe_i(user_oe), .user_in_o(f_user_in),
    .mgmt_out_i(mgmt_out), .mgmt_oe_i(mgmt_oe), .mgmt_in_o(f_mgmt_in),
    .pad_in_i(pad_in), .pad_out_o(f_pad_out), .pad_oe_o(f_pad_oe),
    .pad_mode_o(f_mode), .pad_trip_o(f_trip), .pad_slew_o(f_slew),
    .pad_ana_pol_o(f_pol), .pad_ana_sel_o(f_sel), .pad_ana_en_o(f_aen),
    .pad_ib_o(f_ib), .pad_inp_dis_o(f_idis), .pad_hold_o(f_hold));

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Strobe a word in; it is held from the next rising edge
  task automatic load(input logic [12:0] w);
    @(negedge clk);
    cfg_word = w;
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    #1;
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    mgmt_out = 1'b1; mgmt_oe = 1'b1; pad_in = 1'b1;
    settle();
    check("R1 mode", s_mode, 3'b001);
    check("R1 oe", s_pad_oe, 0);
    check("R1 static", {s_trip,s_slew,s_pol,s_sel,s_aen,s_ib,s_idis,s_hold}, 0);
    check("R1 mgmt_in", s_mgmt_in, 1);
    check("R2 mode", f_mode, 3'b110);
    check("R2 oe", f_pad_oe, 1);
    check("R2 out", f_pad_out, 1);
    mgmt_oe = 1'b0; mgmt_out = 1'b0; settle();
    check("R2 oe follows", f_pad_oe, 0);
    check("R2 out follows", f_pad_out, 0);
  endtask

  task automatic t_transfer();
    @(negedge clk);
    cfg_word = 13'h17FF;
    repeat (3) @(negedge clk);
    settle();
    check("R3 no strobe mode", s_mode, 3'b001);
    check("R3 no strobe trip", s_trip, 0);
    load(13'h1400);
    check("R3 strobed mode", s_mode, 3'b101);
  endtask

  task automatic t_static();
    load(13'h17FF);
    check("R10 mode", s_mode, 3'b101);
    check("R10 bits", {s_trip,s_slew,s_pol,s_sel,s_aen,s_ib,s_idis,s_hold}, 8'hFF);
    load(13'h0204);
    check("R10 trip", s_trip, 1);
    check("R10 hold", s_hold, 1);
    check("R10 others", {s_slew,s_pol,s_sel,s_aen,s_ib,s_idis}, 0);
    check("R10 user owner mode", s_mode, 3'b000);
  endtask

  task automatic t_user();
    load(13'h1800);
    user_out = 1'b1; user_oe = 1'b1; mgmt_out = 1'b0; mgmt_oe = 1'b0; pad_in = 1'b1;
    settle();
    check("R4 out", s_pad_out, 1);
    check("R4 oe", s_pad_oe, 1);
    check("R4 user_in", s_user_in, 1);
    check("R4 mgmt_in", s_mgmt_in, 0);
    check("R4 full out", f_pad_out, 1);
    user_out = 1'b0; user_oe = 1'b0; pad_in = 1'b0; settle();
    check("R4 out low", s_pad_out, 0);
    check("R4 oe low", s_pad_oe, 0);
    check("R4 user_in low", s_user_in, 0);
  endtask

  task automatic t_full();
    load(13'h1803);  // management, output disable bit set
    mgmt_out = 1'b1; mgmt_oe = 1'b1; pad_in = 1'b1; user_out = 1'b0;
    settle();
    check("R5 oe ignores bit1", f_pad_oe, 1);
    check("R5 out", f_pad_out, 1);
    check("R5 mgmt_in", f_mgmt_in, 1);
    check("R5 user_in", f_user_in, 0);
  endtask

  task automatic t_single_out();
    load(13'h1801);
    mgmt_out = 1'b1; mgmt_oe = 1'b0; pad_in = 1'b1;
    settle();
    check("R6 oe", s_pad_oe, 1);
    check("R6 out", s_pad_out, 1);
    check("R6 mgmt_in", s_mgmt_in, 0);
    mgmt_out = 1'b0; settle();
    check("R6 out low", s_pad_out, 0);
  endtask

  task automatic t_single_in();
    load(13'h0403);
    mgmt_out = 1'b1; pad_in = 1'b1;
    settle();
    check("R7 oe", s_pad_oe, 0);
    check("R7 out", s_pad_out, 0);
    check("R7 mgmt_in", s_mgmt_in, 1);
    pad_in = 1'b0; settle();
    check("R7 mgmt_in low", s_mgmt_in, 0);
  endtask

  task automatic t_pull();
    load(13'h0803);  // pull-up
    mgmt_out = 1'b0; pad_in = 1'b1; settle();
    check("R8 up out", s_pad_out, 1);
    check("R8 up oe", s_pad_oe, 0);
    check("R8 up mgmt_in", s_mgmt_in, 1);
    load(13'h0C03);  // pull-down
    mgmt_out = 1'b1; settle();
    check("R8 down out", s_pad_out, 0);
    check("R8 down mgmt_in", s_mgmt_in, 1);
    load(13'h0801);  // pull-up, output disable clear
    mgmt_out = 1'b0; pad_in = 1'b1; settle();
    check("R8 up oe bit1 clear", s_pad_oe, 1);
    check("R8 up out bit1 clear", s_pad_out, 1);
    check("R8 wire stays input", s_mgmt_in, 1);
  endtask

  task automatic t_inp_dis();
    load(13'h040B);
    pad_in = 1'b1; settle();
    check("R9 mgmt_in", s_mgmt_in, 0);
    check("R9 full mgmt_in", f_mgmt_in, 0);
    load(13'h0408);
    settle();
    check("R9 user_in", s_user_in, 0);
    load(13'h0400);
    check("R9 user_in restored", s_user_in, 1);
  endtask

  // Strobe that flips ownership in the same cycle the outputs differ
  task automatic t_same_cycle();
    load(13'h1801);
    @(negedge clk);
    mgmt_out = 1'b0; user_out = 1'b1; user_oe = 1'b1;
    cfg_word = 13'h1800; cfg_load = 1'b1;
    #1;
    check("R3 old owner before edge", s_pad_out, 0);
    @(negedge clk);
    cfg_load = 1'b0;
    #1;
    check("R4 new owner after edge", s_pad_out, 1);
    check("R4 new owner oe", s_pad_oe, 1);
  endtask

  initial begin
    t_reset();
    t_transfer();
    t_static();
    t_user();
    t_full();
    t_single_out();
    t_single_in();
    t_pull();
    t_inp_dis();
    t_same_cycle();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule